// File: doc/BRIEF.md
# I2C Register-Access Slave

This block is a synthesizable I2C target that gives an external bus master byte-wide read and write access to a 256-location register space. The space itself lives outside the block. The block drives a single-cycle write strobe, and it issues a read request whose data must come back one system clock later. SCL and SDA are oversampled by a fast system clock. A START, a repeated START and a STOP are each detected at any point in a transfer.

The device address has seven bits. The top six bits are a fixed prefix and the lowest bit comes from a strap input, so two of these blocks can share one bus. A write transfer first loads an internal 8-bit register pointer and then stores data bytes at successive pointer values. A read transfer streams bytes out from the pointer for as long as the master acknowledges. The pointer is kept across STOP, so a pointer-only write followed by a read fetches from the chosen location.

SDA is open-drain: the block only ever pulls it low. A stuck-low SDA line is cleared by a system-clock counter that releases the line and returns the engine to idle.

Top module: `i2c_reg_slave`

## Requirements
- R1: The block acknowledges an address byte only when its upper seven bits equal {6'b111000, addr_lsb_i}; bit 0 is R/W with 1 meaning read. On a mismatch it leaves SDA released, gives no ACK to any later byte and issues no register access until the next START or STOP.
- R2: Bytes are shifted MSB first on SCL rising edges. After every byte the block accepts, it pulls SDA low (sda_oe_o = 1) for the ninth clock. It changes sda_oe_o only while SCL is low, except on START, STOP or timeout.
- R3: A write of address+W, then a pointer byte, then one data byte stores that data byte at the register named by the pointer byte.
- R4: Each further data byte in a write burst is stored at the previous location plus one.
- R5: A read (address+R) returns the byte at the current pointer. The pointer may be set by an earlier pointer-only write ended by STOP, or by one ended by a repeated START.
- R6: During a read burst, each master ACK makes the block return the byte at the next location. After a master NACK, the block keeps SDA released until the next START or STOP.
- R7: The pointer wraps from FFh to 00h during both write and read auto-increment.
- R8: The pointer keeps its value across STOP, so a later read continues after the last accessed location.
- R9: A repeated START, including one in the middle of a byte, returns the block to address reception without storing the partial byte.
- R10: Out of reset, and after any STOP, SDA is released. A STOP in the middle of a data byte discards that byte.
- R11: If SDA stays low for TIMEOUT_CYCLES system clocks, the block releases SDA and returns to idle. The next transfer then works normally.
- R12: wr_en_o is a single-cycle pulse carrying wr_addr_o and wr_data_o. rd_en_o requests the location on rd_addr_o, and rd_data_i is sampled one clock later. The two strobes are never active in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Sensed SCL line |
| sda_i | input | 1 | Sensed SDA line |
| addr_lsb_i | input | 1 | Strap selecting device address bit 0 |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| wr_en_o | output | 1 | Register write strobe |
| wr_addr_o | output | 8 | Register write location |
| wr_data_o | output | 8 | Register write data |
| rd_en_o | output | 1 | Register read request |
| rd_addr_o | output | 8 | Register read location |
| rd_data_i | input | 8 | Read data, valid the cycle after rd_en_o |

## Verification
The bench builds the block with TIMEOUT_CYCLES = 4000 and two synchronizer stages. This makes the stuck-low release observable within a few thousand clocks, while staying above the longest legitimate low run of SDA. SCL half periods of 40 and 12 system clocks stand in for the slow and fast bus rates. The 12-clock case brings the sampling margin of the synchronizer delay close to its limit. A second device address is reached by flipping the strap pin, and pointer locations FEh and FFh exercise the wrap.

// File: rtl/i2c_regslv_pkg.sv
package i2c_regslv_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_PTR,
        ST_WDAT,
        ST_RDAT,
        ST_MACK,
        ST_ACK_WAIT,
        ST_ACK_DRV,
        ST_SKIP
    } eng_state_e;

    typedef struct packed {
        eng_state_e st;
        eng_state_e after;
        logic [7:0] shreg;
        logic [3:0] cnt;
        logic [7:0] ptr;
        logic       oe;
        logic       load;
    } eng_regs_t;

endpackage

// File: rtl/i2c_line_sampler.sv
module i2c_line_sampler #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [LAST:0] scl_sync_d, scl_sync_q;
    logic [LAST:0] sda_sync_d, sda_sync_q;
    logic          scl_prev_d, scl_prev_q;
    logic          sda_prev_d, sda_prev_q;

    always_comb begin
        scl_sync_d = {scl_sync_q[LAST-1:0], scl_i};
        sda_sync_d = {sda_sync_q[LAST-1:0], sda_i};
        scl_prev_d = scl_sync_q[LAST];
        sda_prev_d = sda_sync_q[LAST];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_sync_q <= '1;
            sda_sync_q <= '1;
            scl_prev_q <= 1'b1;
            sda_prev_q <= 1'b1;
        end else begin
            scl_sync_q <= scl_sync_d;
            sda_sync_q <= sda_sync_d;
            scl_prev_q <= scl_prev_d;
            sda_prev_q <= sda_prev_d;
        end
    end

    assign scl_o      = scl_sync_q[LAST];
    assign sda_o      = sda_sync_q[LAST];
    assign scl_rise_o = scl_o & ~scl_prev_q;
    assign scl_fall_o = ~scl_o & scl_prev_q;
    assign start_o    = scl_o & scl_prev_q & sda_prev_q & ~sda_o;
    assign stop_o     = scl_o & scl_prev_q & ~sda_prev_q & sda_o;

endmodule

// File: rtl/i2c_stuck_timer.sv
module i2c_stuck_timer #(
    parameter int LIMIT = 1250000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sda_i,
    output logic hit_o
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM   = CW'(LIMIT);
    localparam logic [CW-1:0] LIM_1 = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (sda_i)            cnt_d = '0;
        else if (cnt_q == LIM) cnt_d = cnt_q;
        else                  cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign hit_o = ~sda_i & (cnt_q == LIM_1);

endmodule

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave
    import i2c_regslv_pkg::*;
#(
    parameter logic [5:0] DEV_PREFIX     = 6'b111000,
    parameter int         SYNC_STAGES    = 2,
    parameter int         TIMEOUT_CYCLES = 1250000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic       addr_lsb_i,
    output logic       sda_oe_o,
    output logic       wr_en_o,
    output logic [7:0] wr_addr_o,
    output logic [7:0] wr_data_o,
    output logic       rd_en_o,
    output logic [7:0] rd_addr_o,
    input  logic [7:0] rd_data_i
);
    localparam logic [3:0] LAST_BIT = 4'd7;
    localparam logic [3:0] BYTE_LEN = 4'd8;
    localparam eng_regs_t  RST_VAL  = '{st: ST_IDLE, after: ST_IDLE, shreg: 8'h00,
                                        cnt: 4'd0, ptr: 8'h00, oe: 1'b0, load: 1'b0};

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det, to_hit;
    logic [7:0] byte_in;
    eng_regs_t r_d, r_q;

    i2c_line_sampler #(.SYNC_STAGES(SYNC_STAGES)) sampler_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
        .start_o(start_det), .stop_o(stop_det)
    );

    i2c_stuck_timer #(.LIMIT(TIMEOUT_CYCLES)) timer_i (
        .clk(clk), .rst_n(rst_n), .sda_i(sda_s), .hit_o(to_hit)
    );

    assign byte_in   = {r_q.shreg[6:0], sda_s};
    assign wr_addr_o = r_q.ptr;
    assign rd_addr_o = r_q.ptr;
    assign wr_data_o = byte_in;
    assign sda_oe_o  = r_q.oe;

    always_comb begin
        r_d      = r_q;
        r_d.load = 1'b0;
        wr_en_o  = 1'b0;
        rd_en_o  = 1'b0;
        if (r_q.load) r_d.shreg = rd_data_i;

        if (to_hit) begin
            r_d.st = ST_IDLE;
            r_d.oe = 1'b0;
        end else if (stop_det) begin
            r_d.st = ST_IDLE;
            r_d.oe = 1'b0;
        end else if (start_det) begin
            r_d.st  = ST_ADDR;
            r_d.cnt = 4'd0;
            r_d.oe  = 1'b0;
        end else begin
            unique case (r_q.st)
                ST_ADDR, ST_PTR, ST_WDAT: begin
                    if (scl_rise) begin
                        r_d.shreg = byte_in;
                        r_d.cnt   = r_q.cnt + 4'd1;
                        if (r_q.cnt == LAST_BIT) begin
                            r_d.cnt = 4'd0;
                            r_d.st  = ST_ACK_WAIT;
                            if (r_q.st == ST_ADDR) begin
                                if (byte_in[7:1] != {DEV_PREFIX, addr_lsb_i}) begin
                                    r_d.st = ST_SKIP;
                                end else if (byte_in[0]) begin
                                    rd_en_o   = 1'b1;
                                    r_d.load  = 1'b1;
                                    r_d.ptr   = r_q.ptr + 8'd1;
                                    r_d.after = ST_RDAT;
                                end else begin
                                    r_d.after = ST_PTR;
                                end
                            end else if (r_q.st == ST_PTR) begin
                                r_d.ptr   = byte_in;
                                r_d.after = ST_WDAT;
                            end else begin
                                wr_en_o   = 1'b1;
                                r_d.ptr   = r_q.ptr + 8'd1;
                                r_d.after = ST_WDAT;
                            end
                        end
                    end
                end
                ST_ACK_WAIT: begin
                    if (scl_fall) begin
                        r_d.oe = 1'b1;
                        r_d.st = ST_ACK_DRV;
                    end
                end
                ST_ACK_DRV: begin
                    if (scl_fall) begin
                        if (r_q.after == ST_RDAT) begin
                            r_d.oe    = ~r_q.shreg[7];
                            r_d.shreg = {r_q.shreg[6:0], 1'b0};
                            r_d.cnt   = 4'd1;
                        end else begin
                            r_d.oe  = 1'b0;
                            r_d.cnt = 4'd0;
                        end
                        r_d.st = r_q.after;
                    end
                end
                ST_RDAT: begin
                    if (scl_fall) begin
                        if (r_q.cnt == BYTE_LEN) begin
                            r_d.oe  = 1'b0;
                            r_d.cnt = 4'd0;
                            r_d.st  = ST_MACK;
                        end else begin
                            r_d.oe    = ~r_q.shreg[7];
                            r_d.shreg = {r_q.shreg[6:0], 1'b0};
                            r_d.cnt   = r_q.cnt + 4'd1;
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise) begin
                        if (!sda_s) begin
                            rd_en_o   = 1'b1;
                            r_d.load  = 1'b1;
                            r_d.ptr   = r_q.ptr + 8'd1;
                            r_d.after = ST_RDAT;
                            r_d.st    = ST_ACK_DRV;
                        end else begin
                            r_d.st = ST_SKIP;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= RST_VAL;
        else        r_q <= r_d;
    end

    // R12
    wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |=> !wr_en_o);
    // R12
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en_o && rd_en_o));
    // R6
    mack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_MACK) |-> !sda_oe_o);
    // R1
    skip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_SKIP) |-> (!sda_oe_o && !wr_en_o && !rd_en_o));
    // R10
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_det && !to_hit) |=> (!sda_oe_o && r_q.st == ST_IDLE));
    // R11
    timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        to_hit |=> (!sda_oe_o && r_q.st == ST_IDLE));
    // R2
    oe_low_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe_o) |-> (!scl_s || $past(stop_det) || $past(start_det) || $past(to_hit)));

endmodule

// File: tb/i2c_reg_slave_tb.sv
module i2c_reg_slave_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int TO_LIM     = 4000;
    localparam logic [5:0] PFX = 6'b111000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic addr_lsb = 1'b0;
    logic sda_oe, wr_en, rd_en;
    logic [7:0] wr_addr, wr_data, rd_addr;
    logic [7:0] rd_data;
    logic sda_bus;

    assign sda_bus = sda_m & ~sda_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_reg_slave #(.DEV_PREFIX(PFX), .SYNC_STAGES(2), .TIMEOUT_CYCLES(TO_LIM)) dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .addr_lsb_i(addr_lsb),
        .sda_oe_o(sda_oe), .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
        .rd_en_o(rd_en), .rd_addr_o(rd_addr), .rd_data_i(rd_data)
    );

    function automatic logic [7:0] init_val(int i);
        return 8'((i * 37 + 11) | 1);
    endfunction

    // register space attached to the block
    logic [7:0] mem [256];
    int wr_cnt = 0;
    int strobe_bad = 0;
    logic wr_en_prev = 1'b0;
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= init_val(i);
            rd_data <= 8'h00;
        end else begin
            if (wr_en) begin
                mem[wr_addr] <= wr_data;
                wr_cnt <= wr_cnt + 1;
            end
            if (rd_en) rd_data <= mem[rd_addr];
            if ((wr_en && wr_en_prev) || (wr_en && rd_en)) strobe_bad <= strobe_bad + 1;
        end
        wr_en_prev <= wr_en;
    end

    logic [7:0] exp_mem [256];
    logic [7:0] exp_ptr = 8'h00;
    logic [7:0] wbuf [4];
    int hp = 40;
    int n_checks = 0;
    int n_err = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp, input string what);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic m_start();
        sda_m = 1'b1; wt(hp/2);
        scl_m = 1'b1; wt(hp);
        sda_m = 1'b0; wt(hp);
        scl_m = 1'b0; wt(hp/2);
    endtask

    task automatic m_stop();
        sda_m = 1'b0; wt(hp/2);
        scl_m = 1'b1; wt(hp);
        sda_m = 1'b1; wt(hp);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b;    wt(hp/2);
        scl_m = 1'b1; wt(hp);
        scl_m = 1'b0; wt(hp/2);
    endtask

    task automatic recv_bit(output logic b);
        sda_m = 1'b1; wt(hp/2);
        scl_m = 1'b1; wt(hp/2);
        b = sda_bus;  wt(hp/2);
        scl_m = 1'b0; wt(hp/2);
    endtask

    task automatic send_byte(input logic [7:0] v, output logic ack);
        logic a;
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        recv_bit(a);
        ack = ~a;
    endtask

    task automatic recv_byte(output logic [7:0] v, input logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(b);
            v[i] = b;
        end
        send_bit(~ack);
    endtask

    task automatic do_write(input logic [7:0] reg_a, input int n, input string req);
        logic a;
        m_start();
        send_byte({PFX, addr_lsb, 1'b0}, a);
        chk(a, "R1", a, 1, "address ack on write");
        send_byte(reg_a, a);
        chk(a, "R2", a, 1, "pointer byte ack");
        exp_ptr = reg_a;
        for (int k = 0; k < n; k++) begin
            send_byte(wbuf[k], a);
            chk(a, req, a, 1, "data byte ack");
            exp_mem[exp_ptr] = wbuf[k];
            exp_ptr = exp_ptr + 8'd1;
        end
        m_stop();
    endtask

    task automatic do_setptr(input logic [7:0] reg_a);
        logic a;
        m_start();
        send_byte({PFX, addr_lsb, 1'b0}, a);
        chk(a, "R1", a, 1, "address ack on pointer set");
        send_byte(reg_a, a);
        chk(a, "R2", a, 1, "pointer byte ack");
        exp_ptr = reg_a;
        m_stop();
    endtask

    task automatic read_bytes(input int n, input string req);
        logic [7:0] v;
        for (int k = 0; k < n; k++) begin
            recv_byte(v, k < n - 1);
            chk(v == exp_mem[exp_ptr], req, v, exp_mem[exp_ptr], "read byte");
            exp_ptr = exp_ptr + 8'd1;
        end
    endtask

    task automatic do_read(input int n, input string req);
        logic a;
        m_start();
        send_byte({PFX, addr_lsb, 1'b1}, a);
        chk(a, "R1", a, 1, "address ack on read");
        read_bytes(n, req);
        m_stop();
    endtask

    task automatic do_rs_read(input logic [7:0] reg_a, input int n, input string req);
        logic a;
        m_start();
        send_byte({PFX, addr_lsb, 1'b0}, a);
        send_byte(reg_a, a);
        exp_ptr = reg_a;
        m_start();
        send_byte({PFX, addr_lsb, 1'b1}, a);
        chk(a, "R9", a, 1, "address ack after repeated start");
        read_bytes(n, req);
        m_stop();
    endtask

    initial begin : watchdog
        repeat (195000) @(posedge clk);
        n_checks++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin : main
        logic a, b;
        logic [7:0] v;
        int wc;
        void'($urandom(32'h5EED));
        for (int i = 0; i < 256; i++) exp_mem[i] = init_val(i);
        wt(5);
        rst_n = 1'b1;
        wt(5);
        // R10 reset state
        chk(sda_oe == 1'b0, "R10", sda_oe, 0, "SDA released after reset");

        // R3 single write, R5 read back after stop
        wbuf[0] = 8'h3B;
        do_write(8'h12, 1, "R3");
        do_setptr(8'h12);
        do_read(1, "R5");

        // R4 burst write, R8 pointer kept across stop
        wbuf[0] = 8'hA1; wbuf[1] = 8'h57; wbuf[2] = 8'hC3;
        do_write(8'h50, 3, "R4");
        do_setptr(8'h50);
        do_read(3, "R4");
        do_read(2, "R8");

        // R7 wrap on write and read
        wbuf[0] = 8'h11; wbuf[1] = 8'h23; wbuf[2] = 8'h35;
        do_write(8'hFE, 3, "R7");
        chk(exp_ptr == 8'h01, "R7", exp_ptr, 1, "model pointer");
        do_setptr(8'hFF);
        do_read(2, "R7");

        // R1 address mismatch: strap = 1, address sent with lsb 0
        addr_lsb = 1'b1;
        wc = wr_cnt;
        m_start();
        send_byte({PFX, 1'b0, 1'b0}, a);
        chk(!a, "R1", a, 0, "no ack on wrong address");
        send_byte(8'h12, a);
        chk(!a, "R1", a, 0, "no ack on byte after mismatch");
        send_byte(8'h99, a);
        chk(!a, "R1", a, 0, "no ack on data after mismatch");
        m_stop();
        chk(wr_cnt == wc, "R1", wr_cnt, wc, "no write after mismatch");
        wbuf[0] = 8'h6D;
        do_write(8'h21, 1, "R1");
        do_setptr(8'h21);
        do_read(1, "R1");
        addr_lsb = 1'b0;

        // R5 / R9 pointer set ended by repeated start
        do_rs_read(8'h50, 2, "R5");

        // R9 repeated start in the middle of a data byte
        hp = 12;
        wc = wr_cnt;
        m_start();
        send_byte({PFX, addr_lsb, 1'b0}, a);
        send_byte(8'h30, a);
        exp_ptr = 8'h30;
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
        m_start();
        send_byte({PFX, addr_lsb, 1'b1}, a);
        chk(a, "R9", a, 1, "address ack after mid-byte restart");
        read_bytes(1, "R9");
        m_stop();
        chk(wr_cnt == wc, "R9", wr_cnt, wc, "partial byte not stored");

        // R10 stop in the middle of a data byte
        wc = wr_cnt;
        m_start();
        send_byte({PFX, addr_lsb, 1'b0}, a);
        send_byte(8'h60, a);
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
        m_stop();
        exp_ptr = 8'h60;
        chk(wr_cnt == wc, "R10", wr_cnt, wc, "no write on aborted byte");
        chk(sda_oe == 1'b0, "R10", sda_oe, 0, "SDA released after stop");
        do_read(1, "R10");

        // R6 NACK ends burst, SDA stays released
        hp = 40;
        do_setptr(8'h70);
        m_start();
        send_byte({PFX, addr_lsb, 1'b1}, a);
        read_bytes(2, "R6");
        wt(4);
        chk(sda_oe == 1'b0, "R6", sda_oe, 0, "released after NACK");
        recv_bit(b);
        chk(b == 1'b1, "R6", b, 1, "no drive after NACK");
        m_stop();
        exp_ptr = 8'h72;
        do_read(1, "R6");

        // R11 stuck-low timeout while the block drives a zero byte
        hp = 12;
        wbuf[0] = 8'h00;
        do_write(8'h40, 1, "R11");
        do_setptr(8'h40);
        m_start();
        send_byte({PFX, addr_lsb, 1'b1}, a);
        recv_bit(b);
        recv_bit(b);
        wt(5);
        chk(sda_oe == 1'b1, "R11", sda_oe, 1, "driving low before timeout");
        wt(TO_LIM + 200);
        chk(sda_oe == 1'b0 && sda_bus == 1'b1, "R11", sda_oe, 0, "released after timeout");
        m_stop();
        exp_ptr = 8'h41;
        do_read(1, "R11");

        // random mix
        for (int it = 0; it < 12; it++) begin
            hp = ($urandom % 2) ? 40 : 12;
            if ($urandom % 2) begin
                int n = 1 + ($urandom % 3);
                for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom) | 8'h01;
                do_write(8'($urandom), n, "R4");
            end else begin
                do_setptr(8'($urandom));
                do_read(1 + ($urandom % 3), "R6");
            end
        end

        // R12 strobe shape seen by the register space
        chk(strobe_bad == 0, "R12", strobe_bad, 0, "strobe violations");
        // R3 register space contents match model
        for (int i = 0; i < 256; i++) if (mem[i] != exp_mem[i]) begin
            chk(1'b0, "R3", mem[i], exp_mem[i], "stored contents");
        end
        n_checks++;

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end
endmodule